// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a short history of where the processor's program flow last jumped. While the core runs normally, every taken branch or jump raises a capture strobe that carries the fetch address of the target. The buffer keeps the eight most recent such addresses in a circular store. Once eight have been captured, each new capture replaces the oldest one.

When the core stops in debug mode, capture stops and the stored history stays fixed. The read position starts on the oldest stored address. Each read strobe from the debug port steps it one place toward the newest entry. Reads never remove anything, so the buffer never empties. A full pass of eight reads brings the read position back to where it began, and the same history can be read again.

On return to run mode, capture continues from the write position that held before debug entry.

Top module: `cof_trace_fifo`

## Requirements
- R1: After reset, every one of the eight slots holds zero and both positions are slot 0, so `trace_addr` reads 0 and any eight debug reads all return 0.
- R2: In run mode (`debug_mode` = 0), a cycle with `cap_valid` = 1 stores `cap_addr` at the write position and advances that position by one, wrapping from 7 to 0.
- R3: Once more than eight addresses have been captured, each new capture replaces the oldest stored address, so only the eight most recent remain.
- R4: In run mode the read position follows the write position (the oldest slot). In the first debug cycle, `trace_addr` therefore shows the oldest of the eight stored addresses.
- R5: In debug mode, each cycle with `rd_strobe` = 1 advances the read position by one modulo eight. `trace_addr` then shows the next address toward the newest, one cycle after the strobe. Without a strobe, the position holds.
- R6: Eight consecutive debug reads return the read position to the slot it held before the first of them.
- R7: While `debug_mode` = 1, `cap_valid` is ignored. No slot and no write position changes.
- R8: In run mode, `rd_strobe` has no effect. `trace_addr` keeps showing the oldest entry.
- R9: Debug-mode activity leaves the stored addresses untouched. After return to run mode, the next capture lands at the write position that held before debug entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| debug_mode | input | 1 | 1 = core halted in debug, 0 = running |
| cap_valid | input | 1 | Change-of-flow capture strobe |
| cap_addr | input | 32 | Fetch address to capture |
| rd_strobe | input | 1 | Debug read: advance the read position |
| trace_addr | output | 32 | Address in the slot the read position selects |

## Verification
The history is filled in three ways:
- Fewer than eight captures: the oldest slots still hold reset zeros, which shows that the read start is the write position and not slot 0.
- Exactly a full lap of eight captures.
- Thirteen captures: only overwriting of the oldest entries yields the expected order.

Capture strobes and reads are mixed inside one debug session. Together with a full-lap wrap check, this separates frozen contents from silent writes. Read strobes sent in run mode, and a capture right after leaving debug, show that reads never disturb the write side.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

    typedef enum logic [0:0] {
        MODE_RUN   = 1'b0,
        MODE_DEBUG = 1'b1
    } core_mode_e;

endpackage

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot_d [DEPTH];
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end

        // A slot that is not written keeps its address
        assert_slot_frozen_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(slot_q[g]));
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/cof_trace_ptr.sv
module cof_trace_ptr
    import cof_trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  core_mode_e       mode,
    input  logic             cap_valid,
    input  logic             rd_strobe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] rd;
    } ptr_state_s;

    ptr_state_s st_d, st_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        if (p == IDX_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d  = st_q;
        wr_en = cap_valid && (mode == MODE_RUN);
        if (wr_en) begin
            st_d.wr = step(st_q.wr);
        end
        if (mode == MODE_RUN) begin
            st_d.rd = st_d.wr;
        end else if (rd_strobe) begin
            st_d.rd = step(st_q.rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_idx = st_q.wr;
    assign rd_idx = st_q.rd;

    assert_wr_advance_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && mode == MODE_RUN) |=> wr_idx == step($past(wr_idx)));

    assert_wr_frozen_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEBUG) |=> $stable(wr_idx));

    assert_rd_advance_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEBUG && rd_strobe) |=> rd_idx == step($past(rd_idx)));

    assert_rd_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEBUG && !rd_strobe) |=> $stable(rd_idx));

endmodule

// File: rtl/cof_trace_fifo.sv
module cof_trace_fifo
    import cof_trace_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              debug_mode,
    input  logic              cap_valid,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              rd_strobe,
    output logic [ADDR_W-1:0] trace_addr
);

    core_mode_e       mode;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign mode = debug_mode ? MODE_DEBUG : MODE_RUN;

    cof_trace_ptr #(
        .DEPTH (DEPTH)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cap_valid (cap_valid),
        .rd_strobe (rd_strobe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx)
    );

    cof_trace_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (cap_addr),
        .rd_idx  (rd_idx),
        .rd_data (trace_addr)
    );

    // On debug entry the read side starts on the oldest slot
    assert_entry_oldest_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_mode) |-> rd_idx == wr_idx);

    // No store write can occur while halted
    assert_no_write_debug_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> !wr_en);

endmodule

// File: tb/cof_trace_fifo_bench.sv
module cof_trace_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        debug_mode = 1'b0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_addr = '0;
    logic        rd_strobe = 1'b0;
    logic [31:0] trace_addr;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Reference: oldest-first history of 8 and a read offset from oldest
    logic [31:0] hist[$];
    int          roff = 0;

    always #10 clk = ~clk;

    cof_trace_fifo u_cof_trace_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .debug_mode (debug_mode),
        .cap_valid  (cap_valid),
        .cap_addr   (cap_addr),
        .rd_strobe  (rd_strobe),
        .trace_addr (trace_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: trace_addr=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic d, input logic c, input logic [31:0] a, input logic r);
        debug_mode = d;
        cap_valid  = c;
        cap_addr   = a;
        rd_strobe  = r;
        @(posedge clk);
        if (!d) begin
            if (c) begin
                hist.push_back(a);
                void'(hist.pop_front());
            end
            roff = 0;
        end else if (r) begin
            roff = (roff + 1) % 8;
        end
        #3;
        check(cur_req, trace_addr, hist[roff]);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input int i);
        return 32'h4000_0000 + 32'(i) * 32'h0000_0104;
    endfunction

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) hist.push_back(32'h0);
        repeat (3) @(negedge clk);
        check("R1", trace_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", trace_addr, 32'h0);

        // R1: reads of the reset history all return zero
        cur_req = "R1";
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b0, '0, 1'b0);

        // R2: partial fill, oldest slots still zero
        cur_req = "R2";
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, mk(i), 1'b0);
        cyc(1'b0, 1'b0, '0, 1'b0);
        // R4: first debug cycle shows oldest (a reset zero here)
        cur_req = "R4";
        cyc(1'b1, 1'b0, '0, 1'b0);
        check("R4", trace_addr, 32'h0);
        // R5/R6: full pass oldest to newest and back to start
        cur_req = "R5";
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, '0, 1'b1);
        cur_req = "R6";
        cyc(1'b1, 1'b0, '0, 1'b0);
        check("R6", trace_addr, 32'h0);
        cyc(1'b0, 1'b0, '0, 1'b0);

        // R3: 13 more captures overwrite the oldest
        cur_req = "R3";
        for (int i = 10; i < 23; i++) cyc(1'b0, 1'b1, mk(i), 1'b0);
        cur_req = "R4";
        cyc(1'b1, 1'b0, '0, 1'b0);
        check("R3", trace_addr, mk(15));
        // R7: captures during debug mixed with reads
        cur_req = "R7";
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, '0, 1'b1);
        check("R5", trace_addr, mk(18));
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 32'hDEAD_0000 + 32'(i), 1'b0);
        check("R7", trace_addr, mk(18));
        cur_req = "R6";
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 32'hBEEF_0000, 1'b1);
        check("R6", trace_addr, mk(15));

        // R8: read strobes in run mode do nothing
        cur_req = "R8";
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, '0, 1'b1);
        check("R8", trace_addr, mk(15));
        cur_req = "R4";
        cyc(1'b1, 1'b0, '0, 1'b0);
        check("R8", trace_addr, mk(15));

        // R9: partial read pass, then capture resumes at the old write slot
        cur_req = "R9";
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b1, 32'hCAFE_0001, 1'b0);
        cyc(1'b0, 1'b0, '0, 1'b0);
        check("R9", trace_addr, mk(16));
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, '0, 1'b1);
        check("R9", trace_addr, 32'hCAFE_0001);
        cyc(1'b1, 1'b0, '0, 1'b1);
        check("R9", trace_addr, mk(16));

        // R2: exactly one lap of eight
        cur_req = "R2";
        for (int i = 30; i < 38; i++) cyc(1'b0, 1'b1, mk(i), 1'b0);
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, '0, 1'b1);
        check("R2", trace_addr, mk(30));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule